// File: doc/BRIEF.md
# External Oscillator Failure Guard

This block watches an external high-speed oscillator from the domain of an always-running internal reference clock. The monitored clock is brought through a two-flop synchronizer, and each of its transitions restarts a timeout counter. If no transition arrives within `TIMEOUT` reference cycles while the guard is armed, the oscillator is declared failed.

A failure triggers a coordinated response. The oscillator is told to shut down. The system clock is forced to the internal 16 MHz source when it depends on the oscillator, either directly or through the PLL. The PLL is shut down when its input is the oscillator. A one-cycle break event goes to the timers, and a non-maskable interrupt pending flag is raised. The shutdown and fallback requests, and the pending flag, stay latched until software pulses the clear strobe.

Software turns the guard on with a one-cycle enable strobe. The enable is then held internally and drops only on reset or on a detected failure. The guard is armed only while the enable is held, the oscillator is running and its startup is reported complete. It is disarmed at once when the oscillator stops.

Top module: `clk_fail_guard`

## Requirements
- R1: After synchronous reset all five outputs are 0 and the enable is not held.
- R2: A failure can only be declared while the enable is held, `osc_on` is 1 and `osc_ready` is 1. With either of the two oscillator inputs at 0, a stopped monitored clock never raises an output.
- R3: A pulse on `mon_en` sets the held enable, which stays set while `mon_en` is 0. Only reset or a failure clears it, so after a failure the guard stays silent until `mon_en` is pulsed again.
- R4: A monitored clock that toggles more often than once per `TIMEOUT` reference cycles never causes a failure. A stopped monitored clock causes a failure no earlier than `TIMEOUT` and no later than `TIMEOUT+10` reference cycles after its last transition.
- R5: Every failure sets `osc_off_req` to 1.
- R6: A failure sets `force_int16` to 1 when `sys_src` is 2'b01 (oscillator direct), or when `sys_src` is 2'b10 (PLL) and `pll_in_ext` is 1. In every other case `force_int16` stays 0. The other `sys_src` codes are 2'b00 (internal 16 MHz) and 2'b11 (treated as internal).
- R7: A failure sets `pll_off_req` to 1 only when `sys_src` is 2'b10 and `pll_in_ext` is 1.
- R8: `brk_evt` is high for exactly one cycle per failure, in the same cycle in which `nmi_pend` and the requests first show the failure.
- R9: `nmi_pend` stays 1 until a cycle with `irq_clr` high. A failure in the same cycle as `irq_clr` takes priority, so the flag still rises.
- R10: The cycle after `irq_clr` is seen, `nmi_pend`, `osc_off_req`, `force_int16` and `pll_off_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal reference clock, always running |
| rst | input | 1 | Synchronous active-high reset |
| mon_en | input | 1 | Software enable strobe for the guard |
| osc_ready | input | 1 | Oscillator startup delay completed |
| osc_on | input | 1 | Oscillator is switched on |
| sys_src | input | 2 | Current system clock source: 00 int16, 01 ext, 10 PLL, 11 other |
| pll_in_ext | input | 1 | PLL input is the external oscillator, divided or not |
| ext_clk | input | 1 | Monitored external oscillator clock |
| irq_clr | input | 1 | Clear strobe for the pending interrupt and latched actions |
| osc_off_req | output | 1 | Request to disable the external oscillator |
| force_int16 | output | 1 | Force the system clock to the internal 16 MHz source |
| pll_off_req | output | 1 | Request to disable the PLL |
| brk_evt | output | 1 | One-cycle clock-fail event to timer break and fault inputs |
| nmi_pend | output | 1 | Non-maskable interrupt pending flag |

## Verification
Two functions can coincide: the detection of a new failure and a software clear of the interrupt flag. The bench holds `irq_clr` high from before the monitored clock is stopped until after the timeout. It then requires `nmi_pend` to be seen high in exactly one cycle: the failure must win, and the clear must still act in the following cycle. A second overlap is the failure and the dropping of the held enable, which happen together. This is judged by restarting the oscillator without a new enable strobe and requiring silence.

// File: rtl/cfd_pkg.sv
package cfd_pkg;

    typedef enum logic [1:0] {
        SRC_INT16 = 2'b00,
        SRC_EXT   = 2'b01,
        SRC_PLL   = 2'b10,
        SRC_RSVD  = 2'b11
    } sys_src_e;

    typedef struct packed {
        logic osc_off;
        logic to_int16;
        logic pll_off;
    } fail_act_t;

    localparam fail_act_t ACT_NONE = '{osc_off: 1'b0, to_int16: 1'b0, pll_off: 1'b0};

    // Decide which safe-state actions a failure triggers from the clock tree setup.
    function automatic fail_act_t plan_actions(sys_src_e src, logic pll_ext);
        fail_act_t a;
        logic via_pll;
        via_pll    = (src == SRC_PLL) && pll_ext;
        a.osc_off  = 1'b1;
        a.to_int16 = (src == SRC_EXT) || via_pll;
        a.pll_off  = via_pll;
        return a;
    endfunction

endpackage

// File: rtl/cfd_edge_sync.sv
module cfd_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic mon_clk,
    output logic edge_seen
);
    localparam int STAGES = 3;

    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[STAGES-2:0], mon_clk};
    end

    // Any transition after the two synchronizing flops counts as activity.
    assign edge_seen = pipe[STAGES-1] ^ pipe[STAGES-2];
endmodule

// File: rtl/cfd_timeout.sv
module cfd_timeout #(
    parameter int LIMIT = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic armed,
    input  logic edge_seen,
    output logic expired
);
    localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !armed || edge_seen) cnt <= '0;
        else if (cnt != LAST)           cnt <= cnt + 1'b1;
    end

    assign expired = armed && !edge_seen && (cnt == LAST);
endmodule

// File: rtl/cfd_response.sv
module cfd_response
    import cfd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      fail_evt,
    input  sys_src_e  src,
    input  logic      pll_ext,
    input  logic      irq_clr,
    output fail_act_t act,
    output logic      brk,
    output logic      nmi
);
    always_ff @(posedge clk) begin
        if (rst) begin
            act <= ACT_NONE;
            brk <= 1'b0;
            nmi <= 1'b0;
        end else if (fail_evt) begin
            act <= plan_actions(src, pll_ext);
            brk <= 1'b1;
            nmi <= 1'b1;
        end else begin
            brk <= 1'b0;
            if (irq_clr) begin
                act <= ACT_NONE;
                nmi <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/clk_fail_guard.sv
module clk_fail_guard
    import cfd_pkg::*;
#(
    parameter int TIMEOUT = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mon_en,
    input  logic       osc_ready,
    input  logic       osc_on,
    input  logic [1:0] sys_src,
    input  logic       pll_in_ext,
    input  logic       ext_clk,
    input  logic       irq_clr,
    output logic       osc_off_req,
    output logic       force_int16,
    output logic       pll_off_req,
    output logic       brk_evt,
    output logic       nmi_pend
);
    logic      en_q;
    logic      armed;
    logic      edge_seen;
    logic      fail_evt;
    fail_act_t act;

    // Held enable: set by software, dropped only by reset or a failure.
    always_ff @(posedge clk) begin
        if (rst)           en_q <= 1'b0;
        else if (fail_evt) en_q <= 1'b0;
        else if (mon_en)   en_q <= 1'b1;
    end

    assign armed = en_q && osc_on && osc_ready;

    cfd_edge_sync u_sync (
        .clk       (clk),
        .rst       (rst),
        .mon_clk   (ext_clk),
        .edge_seen (edge_seen)
    );

    cfd_timeout #(.LIMIT(TIMEOUT)) u_tmo (
        .clk       (clk),
        .rst       (rst),
        .armed     (armed),
        .edge_seen (edge_seen),
        .expired   (fail_evt)
    );

    cfd_response u_resp (
        .clk      (clk),
        .rst      (rst),
        .fail_evt (fail_evt),
        .src      (sys_src_e'(sys_src)),
        .pll_ext  (pll_in_ext),
        .irq_clr  (irq_clr),
        .act      (act),
        .brk      (brk_evt),
        .nmi      (nmi_pend)
    );

    assign osc_off_req = act.osc_off;
    assign force_int16 = act.to_int16;
    assign pll_off_req = act.pll_off;
endmodule

// File: rtl/clk_fail_guard_chk.sv
module clk_fail_guard_chk (
    input logic clk,
    input logic rst,
    input logic osc_on,
    input logic osc_ready,
    input logic irq_clr,
    input logic osc_off_req,
    input logic force_int16,
    input logic pll_off_req,
    input logic brk_evt,
    input logic nmi_pend
);
    a_r8_brk_single: assert property (@(posedge clk) disable iff (rst)
        brk_evt |=> !brk_evt);

    a_r8_brk_with_nmi: assert property (@(posedge clk) disable iff (rst)
        brk_evt |-> (nmi_pend && osc_off_req));

    a_r9_nmi_sticky: assert property (@(posedge clk) disable iff (rst)
        (nmi_pend && !irq_clr) |=> nmi_pend);

    a_r7_pll_implies_fallback: assert property (@(posedge clk) disable iff (rst)
        pll_off_req |-> force_int16);

    a_r5_actions_with_osc_off: assert property (@(posedge clk) disable iff (rst)
        (force_int16 || pll_off_req) |-> osc_off_req);

    a_r5_rise_with_brk: assert property (@(posedge clk) disable iff (rst)
        $rose(osc_off_req) |-> brk_evt);

    a_r2_armed_source: assert property (@(posedge clk) disable iff (rst)
        brk_evt |-> $past(osc_on && osc_ready));

    a_r10_clear_all: assert property (@(posedge clk) disable iff (rst)
        (irq_clr && !brk_evt && $past(!rst)) |=> (!osc_off_req || brk_evt));
endmodule

bind clk_fail_guard clk_fail_guard_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .osc_on      (osc_on),
    .osc_ready   (osc_ready),
    .irq_clr     (irq_clr),
    .osc_off_req (osc_off_req),
    .force_int16 (force_int16),
    .pll_off_req (pll_off_req),
    .brk_evt     (brk_evt),
    .nmi_pend    (nmi_pend)
);

// File: tb/clk_fail_guard_bench.sv
module clk_fail_guard_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TMO        = 16;
    localparam int EXT_HALF   = 15;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mon_en = 1'b0, osc_ready = 1'b0, osc_on = 1'b0;
    logic [1:0] sys_src = 2'b00;
    logic       pll_in_ext = 1'b0, ext_clk = 1'b0, irq_clr = 1'b0;
    logic       osc_off_req, force_int16, pll_off_req, brk_evt, nmi_pend;
    logic       ext_run = 1'b0;
    logic       done = 1'b0;
    int         errors = 0;
    int         checks = 0;

    clk_fail_guard #(.TIMEOUT(TMO)) u_clk_fail_guard (
        .clk(clk), .rst(rst), .mon_en(mon_en), .osc_ready(osc_ready),
        .osc_on(osc_on), .sys_src(sys_src), .pll_in_ext(pll_in_ext),
        .ext_clk(ext_clk), .irq_clr(irq_clr), .osc_off_req(osc_off_req),
        .force_int16(force_int16), .pll_off_req(pll_off_req),
        .brk_evt(brk_evt), .nmi_pend(nmi_pend)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        forever begin
            if (ext_run) #(EXT_HALF) ext_clk = ~ext_clk;
            else         #(CLK_PERIOD/2);
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cycles(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [4:0] outs();
        return {osc_off_req, force_int16, pll_off_req, brk_evt, nmi_pend};
    endfunction

    // Bring the oscillator up with a running clock, then pulse the enable strobe.
    task automatic start_osc(logic strobe);
        ext_run = 1'b1;
        cycles(4);
        osc_on = 1'b1;
        cycles(2);
        osc_ready = 1'b1;
        if (strobe) begin
            mon_en = 1'b1;
            cycles(1);
            mon_en = 1'b0;
        end
        cycles(10);
    endtask

    task automatic stop_osc();
        ext_run = 1'b0;
        osc_on = 1'b0;
        osc_ready = 1'b0;
        cycles(4);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        cycles(3);
        check("R1 reset outputs", outs(), 5'b0);
        rst = 1'b0;
        cycles(1);
        check("R1 after release", outs(), 5'b0);
    endtask

    task automatic t_healthy();
        sys_src = 2'b01;
        start_osc(1'b1);
        cycles(200);
        check("R4 running clock no failure", outs(), 5'b0);
    endtask

    task automatic t_not_ready();
        ext_run = 1'b0;
        osc_ready = 1'b0;
        cycles(TMO + 12);
        check("R2 not ready no failure", outs(), 5'b0);
        osc_on = 1'b0;
        osc_ready = 1'b1;
        cycles(TMO + 12);
        check("R2 oscillator off no failure", outs(), 5'b0);
        osc_ready = 1'b0;
    endtask

    task automatic t_fail(logic [1:0] src, logic pext, logic exp_f, logic exp_p, string name);
        bit seen = 0;
        sys_src = src;
        pll_in_ext = pext;
        start_osc(1'b1);
        ext_run = 1'b0;
        cycles(TMO);
        check({"R4 not early ", name}, nmi_pend, 1'b0);
        for (int i = 0; i < 12 && !seen; i++) begin
            if (brk_evt) seen = 1;
            else cycles(1);
        end
        check({"R4 failure detected ", name}, seen, 1'b1);
        check({"R8 nmi with brk ", name}, nmi_pend, 1'b1);
        check({"R5 osc off ", name}, osc_off_req, 1'b1);
        check({"R6 fallback ", name}, force_int16, exp_f);
        check({"R7 pll off ", name}, pll_off_req, exp_p);
        cycles(1);
        check({"R8 brk one cycle ", name}, brk_evt, 1'b0);
        osc_on = 1'b0;
        osc_ready = 1'b0;
        cycles(20);
        check({"R9 nmi sticky ", name}, nmi_pend, 1'b1);
        check({"R6 fallback held ", name}, force_int16, exp_f);
        irq_clr = 1'b1;
        cycles(1);
        irq_clr = 1'b0;
        check({"R10 cleared ", name}, outs(), 5'b0);
        stop_osc();
    endtask

    task automatic t_clear_race();
        int hi = 0;
        sys_src = 2'b01;
        pll_in_ext = 1'b0;
        start_osc(1'b1);
        irq_clr = 1'b1;
        ext_run = 1'b0;
        for (int i = 0; i < TMO + 14; i++) begin
            cycles(1);
            if (nmi_pend) hi++;
        end
        irq_clr = 1'b0;
        check("R9 failure wins over clear", hi, 1);
        check("R10 clear follows race", outs(), 5'b0);
        stop_osc();
    endtask

    task automatic t_sticky();
        sys_src = 2'b01;
        start_osc(1'b0);
        ext_run = 1'b0;
        cycles(TMO + 14);
        check("R3 enable dropped by failure", outs(), 5'b0);
        stop_osc();
    endtask

    initial begin
        t_reset();
        t_healthy();
        t_not_ready();
        t_fail(2'b01, 1'b0, 1'b1, 1'b0, "ext direct");
        t_fail(2'b10, 1'b1, 1'b1, 1'b1, "pll from ext");
        t_fail(2'b10, 1'b0, 1'b0, 1'b0, "pll from int");
        t_fail(2'b00, 1'b1, 1'b0, 1'b0, "int16");
        t_fail(2'b11, 1'b1, 1'b0, 1'b0, "other src");
        t_clear_race();
        t_sticky();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule